// File: doc/BRIEF.md
# Lane-Masked Synchronous Dual-Port RAM

A two-port static memory of 4096 words by 36 bits. A left port and a right port each run on their own clock and each can read or write any word at any time. On a rising clock edge a port captures its address, write data and every control input into registers. The memory access takes place on the next rising edge. Read data is registered, so it appears one cycle after the address was captured.

Each word holds four 9-bit lanes, and each lane has its own write request on each port. Lanes 0 and 1 form the low half of the word, bits 17:0. Lanes 2 and 3 form the high half, bits 35:18. Each half has three controls of its own on each port: an enable, a capture enable that can stall the half's input registers, and an output enable that gates its read data without a clock. A lane write is accepted only if the same lane's write request was already high at the previous capture of its half. A write that arrives without that setup capture is dropped and the port reports it with an error pulse. When both ports write the same lane of the same word on the same edge, the left port's data is stored and a collision pulse is raised.

Top module: `dpr_top`

## Requirements
- R1: A read is a capture with the half enabled, the half's capture enable high and none of the half's lane write requests high. It returns that half of the stored word in the read data, with the half's valid bit high for one cycle. This output appears after the second rising edge, counting the capture edge as the first. Every address from 0 to the top one can be written and read back.
- R2: The lanes occupy bits 8:0 (lane 0), 17:9 (lane 1), 26:18 (lane 2) and 35:27 (lane 3). A write changes only the lanes whose write request is high. The other lanes of the word keep their contents.
- R3: A lane write is accepted only if that lane's write request was also high at the previous capture of its half. If it was not, the write is dropped, the word is unchanged, and the port's error output is high for one cycle, at the same time the write would have taken place. Holding a request high over consecutive captures makes each capture after the first an accepted write.
- R4: A read returns the word as it was before any write that takes place on the same edge. This holds for a write from the other port to the same address.
- R5: While a half's capture enable is low, that half captures nothing, including the write-request history, and starts no access. Its valid bit is low for that cycle. A setup capture followed by stalled cycles still allows the next write.
- R6: A half whose enable is low at capture performs no write and no read. Its valid bit stays low and the stored word is unchanged.
- R7: An output enable that is low forces that half's read data to zero and its valid bit low at once, with no clock edge. The other half is not affected.
- R8: If both ports write the same lane of the same address on the same edge, the left port's data is stored. The collision output is then high for one left-clock cycle, with the same timing as R3. Writes to different lanes of the same word both take effect and raise no collision.
- R9: A synchronous active-high reset clears the input registers, the valid bits, the error outputs and the collision output. Memory contents are unspecified after reset.
- R10: The two ports work independently and concurrently. A word written through one port can be read through the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| rst_l | input | 1 | Left port synchronous reset, active high |
| l_addr | input | 12 | Left word address |
| l_wdata | input | 36 | Left write data |
| l_we | input | 4 | Left per-lane write requests, bit n for lane n |
| l_en | input | 2 | Left half enables, bit 0 low half, bit 1 high half |
| l_clken | input | 2 | Left half capture enables |
| l_oe | input | 2 | Left half output enables, asynchronous |
| l_rdata | output | 36 | Left read data |
| l_rvalid | output | 2 | Left per-half read valid |
| l_err | output | 1 | Left pulse for a write dropped by the setup rule |
| coll | output | 1 | Same-lane same-address write collision pulse, left clock |
| clk_r | input | 1 | Right port clock |
| rst_r | input | 1 | Right port synchronous reset, active high |
| r_addr | input | 12 | Right word address |
| r_wdata | input | 36 | Right write data |
| r_we | input | 4 | Right per-lane write requests |
| r_en | input | 2 | Right half enables |
| r_clken | input | 2 | Right half capture enables |
| r_oe | input | 2 | Right half output enables, asynchronous |
| r_rdata | output | 36 | Right read data |
| r_rvalid | output | 2 | Right per-half read valid |
| r_err | output | 1 | Right pulse for a write dropped by the setup rule |

## Verification
The bench builds the block with a 6-bit address, with the lane width and lane count left at their defaults (9 bits, four lanes). With 64 words the bench model can track the whole memory, and the top address, 63, is as easy to write and read as any other. Both ports run on one shared clock. This makes same-edge events happen on demand: collisions, a read racing a write from the other port, and rejected writes without setup. The model checks each of them against the expected lane contents.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    // Number of independently controlled halves of a word.
    localparam int unsigned HALVES = 2;

    // Access kind latched for one half at capture time.
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    // Decide which access a half starts, from its sampled controls.
    function automatic acc_e half_access(input logic enabled, input logic any_write);
        if (!enabled)
            return ACC_NONE;
        return any_write ? ACC_WRITE : ACC_READ;
    endfunction

endpackage

// File: rtl/dpr_port.sv
module dpr_port
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [ADDR_W-1:0]                 addr_i,
    input  logic [LANES*LANE_W-1:0]           wdata_i,
    input  logic [LANES-1:0]                  we_i,
    input  logic [HALVES-1:0]                 en_i,
    input  logic [HALVES-1:0]                 clken_i,
    input  logic [HALVES-1:0]                 oe_i,
    input  logic [LANES*LANE_W-1:0]           mem_rd_i,
    output logic [HALVES-1:0][ADDR_W-1:0]     addr_q_o,
    output logic [LANES*LANE_W-1:0]           wdata_q_o,
    output logic [LANES-1:0]                  wr_ok_o,
    output logic                              err_o,
    output logic [LANES*LANE_W-1:0]           rdata_o,
    output logic [HALVES-1:0]                 rvalid_o
);
    localparam int LPH = LANES / HALVES;
    localparam int HW  = LPH * LANE_W;
    localparam int W   = LANES * LANE_W;

    logic [HALVES-1:0][ADDR_W-1:0] addr_q;
    logic [W-1:0]                  wdata_q;
    logic [LANES-1:0]              we_q;
    logic [LANES-1:0]              we_prev;
    acc_e                          acc_q [HALVES];
    logic [W-1:0]                  rdata_q;
    logic [HALVES-1:0]             rvalid_q;
    logic                          err_q;
    logic [LANES-1:0]              req;

    // Lane write requests that reach the memory stage.
    always_comb begin
        for (int l = 0; l < LANES; l++)
            req[l] = (acc_q[l / LPH] == ACC_WRITE) && we_q[l];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            we_q     <= '0;
            we_prev  <= '0;
            rdata_q  <= '0;
            rvalid_q <= '0;
            err_q    <= 1'b0;
            for (int h = 0; h < HALVES; h++)
                acc_q[h] <= ACC_NONE;
        end else begin
            for (int h = 0; h < HALVES; h++) begin
                // Capture stage, stalled per half by its capture enable.
                if (clken_i[h]) begin
                    addr_q[h]                <= addr_i;
                    wdata_q[h*HW +: HW]      <= wdata_i[h*HW +: HW];
                    we_q[h*LPH +: LPH]       <= we_i[h*LPH +: LPH];
                    we_prev[h*LPH +: LPH]    <= we_q[h*LPH +: LPH];
                    acc_q[h] <= half_access(en_i[h], |we_i[h*LPH +: LPH]);
                end else begin
                    acc_q[h] <= ACC_NONE;
                end
                // Access stage: registered read, old contents.
                rvalid_q[h] <= (acc_q[h] == ACC_READ);
                if (acc_q[h] == ACC_READ)
                    rdata_q[h*HW +: HW] <= mem_rd_i[h*HW +: HW];
            end
            err_q <= |(req & ~we_prev);
        end
    end

    // Asynchronous output gating per half.
    always_comb begin
        for (int h = 0; h < HALVES; h++) begin
            rdata_o[h*HW +: HW] = oe_i[h] ? rdata_q[h*HW +: HW] : '0;
            rvalid_o[h]         = oe_i[h] & rvalid_q[h];
        end
    end

    assign wr_ok_o   = req & we_prev;
    assign addr_q_o  = addr_q;
    assign wdata_q_o = wdata_q;
    assign err_o     = err_q;

    for (genvar h = 0; h < HALVES; h++) begin : g_chk
        // R5
        stall_no_read_chk: assert property (@(posedge clk) disable iff (rst)
            !clken_i[h] |=> ##1 !rvalid_q[h]);
        // R6
        off_no_write_chk: assert property (@(posedge clk) disable iff (rst)
            !en_i[h] |=> (wr_ok_o[h*LPH +: LPH] == '0));
        // R6
        off_no_read_chk: assert property (@(posedge clk) disable iff (rst)
            !en_i[h] |=> ##1 !rvalid_q[h]);
    end

    // R3
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |-> $past(|req));

endmodule

// File: rtl/dpr_store.sv
module dpr_store
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                          clk_l,
    input  logic                          rst_l,
    input  logic                          clk_r,
    input  logic [LANES-1:0]              l_ok_i,
    input  logic [LANES-1:0]              r_ok_i,
    input  logic [HALVES-1:0][ADDR_W-1:0] l_addr_i,
    input  logic [HALVES-1:0][ADDR_W-1:0] r_addr_i,
    input  logic [LANES*LANE_W-1:0]       l_wd_i,
    input  logic [LANES*LANE_W-1:0]       r_wd_i,
    output logic [LANES*LANE_W-1:0]       l_rd_o,
    output logic [LANES*LANE_W-1:0]       r_rd_o,
    output logic                          coll_o
);
    localparam int LPH   = LANES / HALVES;
    localparam int HW    = LPH * LANE_W;
    localparam int W     = LANES * LANE_W;
    localparam int DEPTH = 1 << ADDR_W;

    // Each port owns one bank; a word is the XOR of both banks.
    logic [W-1:0]     bank_l [DEPTH];
    logic [W-1:0]     bank_r [DEPTH];
    logic [LANES-1:0] clash;
    logic [LANES-1:0] r_eff;
    logic             coll_q;

    always_comb begin
        for (int l = 0; l < LANES; l++)
            clash[l] = l_ok_i[l] && r_ok_i[l] && (l_addr_i[l / LPH] == r_addr_i[l / LPH]);
        r_eff = r_ok_i & ~clash;
    end

    always_ff @(posedge clk_l) begin
        for (int l = 0; l < LANES; l++)
            if (l_ok_i[l])
                bank_l[l_addr_i[l / LPH]][l*LANE_W +: LANE_W] <=
                    l_wd_i[l*LANE_W +: LANE_W] ^ bank_r[l_addr_i[l / LPH]][l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk_r) begin
        for (int l = 0; l < LANES; l++)
            if (r_eff[l])
                bank_r[r_addr_i[l / LPH]][l*LANE_W +: LANE_W] <=
                    r_wd_i[l*LANE_W +: LANE_W] ^ bank_l[r_addr_i[l / LPH]][l*LANE_W +: LANE_W];
    end

    always_comb begin
        logic [W-1:0] lw;
        logic [W-1:0] rw;
        for (int h = 0; h < HALVES; h++) begin
            lw = bank_l[l_addr_i[h]] ^ bank_r[l_addr_i[h]];
            rw = bank_l[r_addr_i[h]] ^ bank_r[r_addr_i[h]];
            l_rd_o[h*HW +: HW] = lw[h*HW +: HW];
            r_rd_o[h*HW +: HW] = rw[h*HW +: HW];
        end
    end

    always_ff @(posedge clk_l) begin
        if (rst_l) coll_q <= 1'b0;
        else       coll_q <= |clash;
    end

    assign coll_o = coll_q;

    // R8
    coll_cause_chk: assert property (@(posedge clk_l) disable iff (rst_l)
        coll_q |-> $past(|(l_ok_i & r_ok_i)));

endmodule

// File: rtl/dpr_top.sv
module dpr_top
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                    clk_l,
    input  logic                    rst_l,
    input  logic [ADDR_W-1:0]       l_addr,
    input  logic [LANES*LANE_W-1:0] l_wdata,
    input  logic [LANES-1:0]        l_we,
    input  logic [HALVES-1:0]       l_en,
    input  logic [HALVES-1:0]       l_clken,
    input  logic [HALVES-1:0]       l_oe,
    output logic [LANES*LANE_W-1:0] l_rdata,
    output logic [HALVES-1:0]       l_rvalid,
    output logic                    l_err,
    output logic                    coll,
    input  logic                    clk_r,
    input  logic                    rst_r,
    input  logic [ADDR_W-1:0]       r_addr,
    input  logic [LANES*LANE_W-1:0] r_wdata,
    input  logic [LANES-1:0]        r_we,
    input  logic [HALVES-1:0]       r_en,
    input  logic [HALVES-1:0]       r_clken,
    input  logic [HALVES-1:0]       r_oe,
    output logic [LANES*LANE_W-1:0] r_rdata,
    output logic [HALVES-1:0]       r_rvalid,
    output logic                    r_err
);
    logic [HALVES-1:0][ADDR_W-1:0] la_q, ra_q;
    logic [LANES*LANE_W-1:0]       lwd_q, rwd_q, lrd, rrd;
    logic [LANES-1:0]              l_ok, r_ok;

    dpr_port #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_left (
        .clk(clk_l), .rst(rst_l), .addr_i(l_addr), .wdata_i(l_wdata), .we_i(l_we),
        .en_i(l_en), .clken_i(l_clken), .oe_i(l_oe), .mem_rd_i(lrd),
        .addr_q_o(la_q), .wdata_q_o(lwd_q), .wr_ok_o(l_ok), .err_o(l_err),
        .rdata_o(l_rdata), .rvalid_o(l_rvalid));

    dpr_port #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_right (
        .clk(clk_r), .rst(rst_r), .addr_i(r_addr), .wdata_i(r_wdata), .we_i(r_we),
        .en_i(r_en), .clken_i(r_clken), .oe_i(r_oe), .mem_rd_i(rrd),
        .addr_q_o(ra_q), .wdata_q_o(rwd_q), .wr_ok_o(r_ok), .err_o(r_err),
        .rdata_o(r_rdata), .rvalid_o(r_rvalid));

    dpr_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_store (
        .clk_l(clk_l), .rst_l(rst_l), .clk_r(clk_r),
        .l_ok_i(l_ok), .r_ok_i(r_ok), .l_addr_i(la_q), .r_addr_i(ra_q),
        .l_wd_i(lwd_q), .r_wd_i(rwd_q), .l_rd_o(lrd), .r_rd_o(rrd), .coll_o(coll));

endmodule

// File: tb/sim_dpr_top.sv
`timescale 1ns/1ps
module sim_dpr_top;
    localparam int AW = 6;
    localparam int LW = 9;
    localparam int NL = 4;
    localparam int W  = NL * LW;

    typedef struct {
        logic [AW-1:0] a;
        logic [W-1:0]  d;
        logic [NL-1:0] we;
        logic [1:0]    en;
        logic [1:0]    ck;
        logic [1:0]    oe;
    } pin_t;

    typedef struct {
        int          due;
        logic [W-1:0] ld;
        logic [W-1:0] rd;
        logic [1:0]  lv;
        logic [1:0]  rv;
        logic        le;
        logic        re;
        logic        co;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [W-1:0]  l_wdata = '0, r_wdata = '0;
    logic [NL-1:0] l_we = '0, r_we = '0;
    logic [1:0]    l_en = '0, r_en = '0, l_clken = 2'b11, r_clken = 2'b11, l_oe = 2'b11, r_oe = 2'b11;
    logic [W-1:0]  l_rdata, r_rdata;
    logic [1:0]    l_rvalid, r_rvalid;
    logic          l_err, r_err, coll;

    exp_t          sb [$];
    logic [W-1:0]  ref_mem [64];
    logic [NL-1:0] pl = '0, pr = '0;
    int            checks = 0, fails = 0, pcount = 0;

    always #10 clk = ~clk;

    dpr_top #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) u0 (
        .clk_l(clk), .rst_l(rst), .l_addr(l_addr), .l_wdata(l_wdata), .l_we(l_we),
        .l_en(l_en), .l_clken(l_clken), .l_oe(l_oe), .l_rdata(l_rdata),
        .l_rvalid(l_rvalid), .l_err(l_err), .coll(coll),
        .clk_r(clk), .rst_r(rst), .r_addr(r_addr), .r_wdata(r_wdata), .r_we(r_we),
        .r_en(r_en), .r_clken(r_clken), .r_oe(r_oe), .r_rdata(r_rdata),
        .r_rvalid(r_rvalid), .r_err(r_err));

    always @(posedge clk) pcount++;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic pin_t idle();
        pin_t p;
        p.a = '0; p.d = '0; p.we = '0; p.en = 2'b00; p.ck = 2'b11; p.oe = 2'b11;
        return p;
    endfunction

    function automatic pin_t rdp(input logic [AW-1:0] a);
        pin_t p = idle();
        p.a = a; p.en = 2'b11;
        return p;
    endfunction

    function automatic pin_t wrp(input logic [AW-1:0] a, input logic [W-1:0] d,
                                 input logic [NL-1:0] we, input logic [1:0] en);
        pin_t p = idle();
        p.a = a; p.d = d; p.we = we; p.en = en;
        return p;
    endfunction

    // Port model built from the requirements (R1, R3, R5, R6).
    task automatic model(input pin_t p, input logic [NL-1:0] prev_in,
                         output logic [NL-1:0] prev_out, output logic [W-1:0] rd,
                         output logic [1:0] v, output logic e, output logic [NL-1:0] acc);
        rd = '0; v = '0; e = 1'b0; acc = '0; prev_out = prev_in;
        for (int h = 0; h < 2; h++) begin
            if (p.ck[h]) begin
                for (int l = h*2; l < h*2 + 2; l++) begin
                    if (p.en[h] && p.we[l]) begin
                        if (prev_in[l]) acc[l] = 1'b1;
                        else            e = 1'b1;
                    end
                    prev_out[l] = p.we[l];
                end
                if (p.en[h] && p.we[h*2 +: 2] == 2'b00) begin
                    v[h] = 1'b1;
                    rd[h*18 +: 18] = ref_mem[p.a][h*18 +: 18];
                end
            end
        end
    endtask

    task automatic step(input pin_t L, input pin_t R, input string tag);
        exp_t e;
        logic [NL-1:0] al, ar, npl, npr;
        @(negedge clk);
        l_addr = L.a; l_wdata = L.d; l_we = L.we; l_en = L.en; l_clken = L.ck; l_oe = L.oe;
        r_addr = R.a; r_wdata = R.d; r_we = R.we; r_en = R.en; r_clken = R.ck; r_oe = R.oe;
        model(L, pl, npl, e.ld, e.lv, e.le, al);
        model(R, pr, npr, e.rd, e.rv, e.re, ar);
        pl = npl; pr = npr;
        e.co = 1'b0;
        for (int l = 0; l < NL; l++) begin
            if (al[l] && ar[l] && L.a == R.a) e.co = 1'b1;
            else if (ar[l]) ref_mem[R.a][l*LW +: LW] = R.d[l*LW +: LW];
        end
        for (int l = 0; l < NL; l++)
            if (al[l]) ref_mem[L.a][l*LW +: LW] = L.d[l*LW +: LW];
        e.due = pcount + 2;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic lwrite(input logic [AW-1:0] a, input logic [W-1:0] d,
                          input logic [NL-1:0] we, input string tag);
        step(wrp(a, d, we, 2'b00), idle(), tag);
        step(wrp(a, d, we, 2'b11), idle(), tag);
        step(idle(), idle(), tag);
    endtask

    task automatic rwrite(input logic [AW-1:0] a, input logic [W-1:0] d,
                          input logic [NL-1:0] we, input string tag);
        step(idle(), wrp(a, d, we, 2'b00), tag);
        step(idle(), wrp(a, d, we, 2'b11), tag);
        step(idle(), idle(), tag);
    endtask

    // Monitor: pops due items and compares; output enable is applied at sample time (R7).
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #5;
            while (sb.size() > 0 && sb[0].due == pcount) begin
                e = sb.pop_front();
                for (int h = 0; h < 2; h++) begin
                    chk(l_rvalid[h] == (e.lv[h] & l_oe[h]), e.tag, "left valid",
                        W'(l_rvalid), W'(e.lv & l_oe));
                    chk(r_rvalid[h] == (e.rv[h] & r_oe[h]), e.tag, "right valid",
                        W'(r_rvalid), W'(e.rv & r_oe));
                    if (e.lv[h] || !l_oe[h])
                        chk(l_rdata[h*18 +: 18] == (l_oe[h] ? e.ld[h*18 +: 18] : 18'd0),
                            e.tag, "left data", l_rdata, e.ld);
                    if (e.rv[h] || !r_oe[h])
                        chk(r_rdata[h*18 +: 18] == (r_oe[h] ? e.rd[h*18 +: 18] : 18'd0),
                            e.tag, "right data", r_rdata, e.rd);
                end
                chk(l_err == e.le, e.tag, "left err", W'(l_err), W'(e.le));
                chk(r_err == e.re, e.tag, "right err", W'(r_err), W'(e.re));
                chk(coll == e.co, e.tag, "collision", W'(coll), W'(e.co));
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        checks++; fails++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        pin_t p, q;
        repeat (3) @(posedge clk);
        #5;
        // R9: outputs cleared by reset
        chk(l_rvalid == 2'b00 && r_rvalid == 2'b00, "R9", "valid", W'({l_rvalid, r_rvalid}), '0);
        chk(l_err == 1'b0 && r_err == 1'b0, "R9", "err", W'({l_err, r_err}), '0);
        chk(coll == 1'b0, "R9", "coll", W'(coll), '0);
        chk(l_rdata == '0 && r_rdata == '0, "R9", "rdata", l_rdata | r_rdata, '0);
        @(negedge clk);
        rst = 1'b0;

        // R1 / R10: full write, read both ports, top address
        lwrite(6'd5, 36'h1_2345_6789, 4'b1111, "R1");
        step(rdp(6'd5), idle(), "R1");
        step(idle(), rdp(6'd5), "R10");
        rwrite(6'd63, 36'hA_BCDE_F012, 4'b1111, "R1");
        step(rdp(6'd63), idle(), "R1");

        // R2: lane 1 only
        rwrite(6'd5, 36'hF_FFFF_FFFF, 4'b0010, "R2");
        step(rdp(6'd5), rdp(6'd5), "R2");

        // R3: write without setup is dropped
        lwrite(6'd7, 36'h0_0000_7777, 4'b1111, "R3");
        step(wrp(6'd7, 36'h5_5555_5555, 4'b1111, 2'b11), idle(), "R3");
        step(idle(), idle(), "R3");
        step(rdp(6'd7), idle(), "R3");
        // R3: held request, back-to-back accepted writes
        step(wrp(6'd8, '0, 4'b1111, 2'b00), idle(), "R3");
        step(wrp(6'd8, 36'h8_8888_8888, 4'b1111, 2'b11), idle(), "R3");
        step(wrp(6'd9, 36'h9_9999_9999, 4'b1111, 2'b11), idle(), "R3");
        step(idle(), idle(), "R3");
        step(rdp(6'd8), rdp(6'd9), "R3");

        // R5: stall keeps setup history and starts nothing
        step(wrp(6'd10, '0, 4'b0011, 2'b00), idle(), "R5");
        p = wrp(6'd10, 36'h1_1111_1111, 4'b0000, 2'b11); p.ck = 2'b00;
        step(p, idle(), "R5");
        step(p, idle(), "R5");
        step(wrp(6'd10, 36'h0_0003_1234, 4'b0011, 2'b11), idle(), "R5");
        step(idle(), idle(), "R5");
        step(rdp(6'd10), idle(), "R5");
        p = rdp(6'd5); p.ck = 2'b01;
        step(p, idle(), "R5");

        // R6: disabled half neither reads nor writes
        p = rdp(6'd5); p.en = 2'b01;
        step(p, idle(), "R6");
        step(wrp(6'd5, '0, 4'b1100, 2'b00), idle(), "R6");
        step(wrp(6'd5, 36'h0_0000_0000, 4'b1100, 2'b01), idle(), "R6");
        step(idle(), idle(), "R6");
        step(rdp(6'd5), idle(), "R6");

        // R7: output enable gating at sample time
        step(rdp(6'd63), rdp(6'd63), "R7");
        p = idle(); p.oe = 2'b10;
        q = idle(); q.oe = 2'b01;
        step(p, q, "R7");
        p.oe = 2'b00;
        step(p, idle(), "R7");
        step(idle(), idle(), "R7");

        // R8: same lane collision, left wins
        step(wrp(6'd20, '0, 4'b1111, 2'b00), wrp(6'd20, '0, 4'b0011, 2'b00), "R8");
        step(wrp(6'd20, 36'hC_CCCC_CCCC, 4'b1111, 2'b11),
             wrp(6'd20, 36'h3_3333_3333, 4'b0011, 2'b11), "R8");
        step(idle(), idle(), "R8");
        step(rdp(6'd20), rdp(6'd20), "R8");
        // R8: different lanes, no collision
        step(wrp(6'd21, '0, 4'b0001, 2'b00), wrp(6'd21, '0, 4'b1000, 2'b00), "R8");
        step(wrp(6'd21, 36'h0_0000_01AB, 4'b0001, 2'b11),
             wrp(6'd21, 36'h1_5000_0000, 4'b1000, 2'b11), "R8");
        step(idle(), idle(), "R8");
        step(rdp(6'd21), rdp(6'd21), "R8");

        // R4: read racing a write from the other port returns old data
        lwrite(6'd30, 36'h3_0303_0303, 4'b1111, "R4");
        step(wrp(6'd30, '0, 4'b1111, 2'b00), idle(), "R4");
        step(wrp(6'd30, 36'h6_0606_0606, 4'b1111, 2'b11), rdp(6'd30), "R4");
        step(idle(), idle(), "R4");
        step(idle(), rdp(6'd30), "R4");

        // R10: concurrent independent traffic
        step(rdp(6'd63), wrp(6'd40, '0, 4'b1111, 2'b00), "R10");
        step(rdp(6'd9), wrp(6'd40, 36'h4_4040_4040, 4'b1111, 2'b11), "R10");
        step(idle(), idle(), "R10");
        step(rdp(6'd40), rdp(6'd8), "R10");

        repeat (4) step(idle(), idle(), "R9");
        repeat (2) @(posedge clk);
        #6;
        finish_run();
    end
endmodule